// File: doc/BRIEF.md
# Address-Triggered Context Latch Bank

This block is a small bank of one-bit control latches inside a memory controller. Each latch owns two bus addresses. An access to one address sets the latch and an access to the other clears it. The data bus plays no part, so a read has the same effect as a write. There are five latches: two segment bits that select the user memory-map context, a bit that enables the map-programming (setup) mode, and enable bits for soft and hard memory-error reporting.

The block drives the active two-bit context number to the translation logic. While the processor is in supervisor state the context is forced to 0. When supervisor state ends, the context returns to the value in the segment latches with no further access. A small bus-cycle state machine decides when an access counts. The named states are `ST_IDLE` (no strobe), `ST_RD_CYC` (a read access is in progress) and `ST_WR_CYC` (a write access is in progress).

The transitions are as follows:
- Idle to read or write, on the first strobed cycle. This transition fires the access.
- Read to write, or write to read, on a change of direction while the strobe stays high. This transition fires the access again.
- Read or write to idle, when the strobe drops.

A strobed cycle that keeps the same direction fires nothing.

Top module: `ctx_latch_bank`

## Requirements
- R1: Latch i (0 = segment-low, 1 = segment-high, 2 = setup, 3 = soft-error enable, 4 = hard-error enable) is cleared by an access to BASE_ADDR+LATCH_STRIDE*i and set by an access to BASE_ADDR+LATCH_STRIDE*i+2. With the defaults, BASE_ADDR is 16'hE000 and LATCH_STRIDE is 4.
- R2: A read access (bus_rd=1) changes a latch exactly as a write access (bus_rd=0) does.
- R3: An access to any address outside the ten mapped addresses, or a cycle with bus_strobe low, leaves all five latches unchanged.
- R4: While supervisor is 1, ctx is 0 whatever the segment latches hold.
- R5: While supervisor is 0, ctx equals {segment-high, segment-low}, so every value from 0 to 3 can be reached.
- R6: When supervisor falls, ctx shows the segment latch value in the same cycle, with no access needed.
- R7: Repeating an access to the same address leaves the latch as a single access does. This holds for back-to-back accesses and for a read followed by a write under one held strobe.
- R8: Reset clears all latches: ctx=0, setup_mode=0, soft_err_en=0, hard_err_en=0.
- R9: A latch takes its new value at the clock edge that ends the first strobed cycle of an access. During that cycle the outputs still show the old value.
- R10: While the strobe stays high and the direction does not change, a change of address has no effect. The address is taken only when an access fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_strobe | input | 1 | Address strobe, high while an access is in progress |
| bus_rd | input | 1 | 1 for read, 0 for write |
| supervisor | input | 1 | Processor supervisor state |
| ctx | output | 2 | Active context number |
| setup_mode | output | 1 | Map-programming mode enable |
| soft_err_en | output | 1 | Soft memory-error reporting enable |
| hard_err_en | output | 1 | Hard memory-error reporting enable |

## Verification
Two functions can fall in the same cycle, and both are provoked on purpose.

The first pair is the supervisor override and a write to a segment latch. The bench raises supervisor, sets both segment latches while it is high and confirms that ctx stays 0. It then drops supervisor and, without any access, expects ctx to read 3.

The second pair is a read and a write to one address under a single held strobe. The bench flips bus_rd in mid-access and judges the outcome against one lone access. It also moves the address under a held strobe and expects no change.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int NUM_LATCH = 5;

    typedef enum logic [2:0] {
        LT_SEG_LO   = 3'd0,
        LT_SEG_HI   = 3'd1,
        LT_SETUP    = 3'd2,
        LT_SOFT_ERR = 3'd3,
        LT_HARD_ERR = 3'd4
    } latch_id_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_CYC = 2'd1,
        ST_WR_CYC = 2'd2
    } bus_state_e;

endpackage

// File: rtl/clb_bus_fsm.sv
module clb_bus_fsm
    import clb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_strobe,
    input  logic bus_rd,
    output logic access_fire
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = ST_IDLE;
        access_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_strobe) begin
                    access_fire = 1'b1;
                    state_d     = bus_rd ? ST_RD_CYC : ST_WR_CYC;
                end
            end
            ST_RD_CYC: begin
                if (bus_strobe) begin
                    access_fire = !bus_rd;
                    state_d     = bus_rd ? ST_RD_CYC : ST_WR_CYC;
                end
            end
            ST_WR_CYC: begin
                if (bus_strobe) begin
                    access_fire = bus_rd;
                    state_d     = bus_rd ? ST_RD_CYC : ST_WR_CYC;
                end
            end
            default: begin
                state_d     = ST_IDLE;
                access_fire = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clb_decode.sv
module clb_decode
    import clb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BASE_ADDR    = 'hE000,
    parameter int LATCH_STRIDE = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LATCH-1:0] set_hit,
    output logic [NUM_LATCH-1:0] clr_hit
);

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + LATCH_STRIDE * i);
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR + LATCH_STRIDE * i + 2);
        assign clr_hit[i] = (addr == CLR_A);
        assign set_hit[i] = (addr == SET_A);
    end

endmodule

// File: rtl/clb_latch_cell.sv
module clb_latch_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic set_hit,
    input  logic clr_hit,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (fire && set_hit)  q <= 1'b1;
        else if (fire && clr_hit)  q <= 1'b0;
    end

endmodule

// File: rtl/ctx_latch_bank.sv
module ctx_latch_bank
    import clb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BASE_ADDR    = 'hE000,
    parameter int LATCH_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              bus_rd,
    input  logic              supervisor,
    output logic [1:0]        ctx,
    output logic              setup_mode,
    output logic              soft_err_en,
    output logic              hard_err_en
);

    logic                 access_fire;
    logic [NUM_LATCH-1:0] set_hit;
    logic [NUM_LATCH-1:0] clr_hit;
    logic [NUM_LATCH-1:0] latch_q;

    clb_bus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_strobe  (bus_strobe),
        .bus_rd      (bus_rd),
        .access_fire (access_fire)
    );

    clb_decode #(
        .ADDR_W       (ADDR_W),
        .BASE_ADDR    (BASE_ADDR),
        .LATCH_STRIDE (LATCH_STRIDE)
    ) u_dec (
        .addr    (bus_addr),
        .set_hit (set_hit),
        .clr_hit (clr_hit)
    );

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_cell
        clb_latch_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (access_fire),
            .set_hit (set_hit[i]),
            .clr_hit (clr_hit[i]),
            .q       (latch_q[i])
        );
    end

    // Supervisor state forces context 0; user context is rebuilt from the segment bits.
    always_comb begin
        if (supervisor) ctx = 2'd0;
        else            ctx = {latch_q[LT_SEG_HI], latch_q[LT_SEG_LO]};
        setup_mode  = latch_q[LT_SETUP];
        soft_err_en = latch_q[LT_SOFT_ERR];
        hard_err_en = latch_q[LT_HARD_ERR];
    end

endmodule

// File: rtl/clb_checker.sv
module clb_checker
    import clb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BASE_ADDR    = 'hE000,
    parameter int LATCH_STRIDE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_strobe,
    input logic                 supervisor,
    input logic [1:0]           ctx,
    input logic [NUM_LATCH-1:0] latch_q
);

    logic prev_strobe;
    always_ff @(posedge clk) begin
        if (!rst_n) prev_strobe <= 1'b0;
        else        prev_strobe <= bus_strobe;
    end

    assert_sup_ctx_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        supervisor |-> (ctx == 2'd0));

    assert_user_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !supervisor |-> (ctx == {latch_q[1], latch_q[0]}));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> $stable(latch_q));

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_map
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + LATCH_STRIDE * i);
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR + LATCH_STRIDE * i + 2);

        assert_set_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_strobe && !prev_strobe && bus_addr == SET_A) |=> latch_q[i]);

        assert_clr_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_strobe && !prev_strobe && bus_addr == CLR_A) |=> !latch_q[i]);
    end

endmodule

bind ctx_latch_bank clb_checker #(
    .ADDR_W       (ADDR_W),
    .BASE_ADDR    (BASE_ADDR),
    .LATCH_STRIDE (LATCH_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_strobe (bus_strobe),
    .supervisor (supervisor),
    .ctx        (ctx),
    .latch_q    (latch_q)
);

// File: tb/ctx_latch_bank_test.sv
`timescale 1ns/1ps
module ctx_latch_bank_test;

    localparam int AW   = 16;
    localparam int BASE = 'hE000;
    localparam int STR  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_strobe = 1'b0;
    logic          bus_rd = 1'b0;
    logic          supervisor = 1'b0;
    logic [1:0]    ctx;
    logic          setup_mode, soft_err_en, hard_err_en;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_l = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctx_latch_bank #(.ADDR_W(AW), .BASE_ADDR(BASE), .LATCH_STRIDE(STR)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .bus_rd(bus_rd), .supervisor(supervisor), .ctx(ctx), .setup_mode(setup_mode),
        .soft_err_en(soft_err_en), .hard_err_en(hard_err_en)
    );

    function automatic logic [AW-1:0] clr_a(int i); return AW'(BASE + STR*i);     endfunction
    function automatic logic [AW-1:0] set_a(int i); return AW'(BASE + STR*i + 2); endfunction

    task automatic check(string req, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic [4:0] observed();
        return {hard_err_en, soft_err_en, setup_mode, ctx};
    endfunction

    function automatic logic [4:0] expected();
        logic [1:0] c = supervisor ? 2'd0 : {exp_l[1], exp_l[0]};
        return {exp_l[4], exp_l[3], exp_l[2], c};
    endfunction

    task automatic access(logic [AW-1:0] a, logic rd);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8", observed(), 5'b0);

        // R1 R2: sweep every latch, set/clear by both read and write
        for (int i = 0; i < 5; i++) begin
            access(set_a(i), 1'b1); exp_l[i] = 1'b1; check("R1/R2 set-by-read", observed(), expected());
            access(clr_a(i), 1'b0); exp_l[i] = 1'b0; check("R1/R2 clr-by-write", observed(), expected());
            access(set_a(i), 1'b0); exp_l[i] = 1'b1; check("R1/R2 set-by-write", observed(), expected());
            access(clr_a(i), 1'b1); exp_l[i] = 1'b0; check("R1/R2 clr-by-read", observed(), expected());
            access(set_a(i), i[0]); exp_l[i] = 1'b1; check("R1 keep-set", observed(), expected());
        end

        // R5: all four user contexts
        for (int c = 0; c < 4; c++) begin
            access(c[0] ? set_a(0) : clr_a(0), 1'b1);
            access(c[1] ? set_a(1) : clr_a(1), 1'b0);
            exp_l[0] = c[0]; exp_l[1] = c[1];
            check("R5 user ctx", observed(), expected());
        end

        // R3: unmapped addresses and nearby offsets
        begin
            logic [AW-1:0] miss [7];
            miss[0] = AW'(BASE-2); miss[1] = AW'(BASE+1); miss[2] = AW'(BASE+3);
            miss[3] = AW'(BASE+STR*5); miss[4] = AW'(BASE+STR*5+2);
            miss[5] = '0; miss[6] = '1;
            for (int k = 0; k < 7; k++) begin
                access(miss[k], k[0]);
                check("R3 miss addr", observed(), expected());
            end
        end
        // R3: address on bus at a mapped location but strobe low
        @(negedge clk); bus_addr = clr_a(4); bus_strobe = 1'b0;
        @(negedge clk); check("R3 no strobe", observed(), expected());

        // R4 R6: override while segment write happens in the same window
        access(clr_a(0), 1'b0); access(clr_a(1), 1'b0); exp_l[1:0] = 2'b00;
        @(negedge clk); supervisor = 1'b1;
        access(set_a(0), 1'b0); access(set_a(1), 1'b1); exp_l[1:0] = 2'b11;
        check("R4 sup ctx", observed(), expected());
        @(negedge clk); supervisor = 1'b0; #1;
        check("R6 return ctx", observed(), expected());

        // R9: old value visible during first strobed cycle
        @(negedge clk);
        bus_addr = clr_a(2); bus_rd = 1'b0; bus_strobe = 1'b1; exp_l[2] = 1'b1;
        #2; check("R9 before edge", observed(), expected());
        @(negedge clk); bus_strobe = 1'b0; exp_l[2] = 1'b0;
        check("R9 after edge", observed(), expected());

        // R7: read then write under one held strobe, and back-to-back
        @(negedge clk); bus_addr = set_a(3); bus_rd = 1'b1; bus_strobe = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        @(negedge clk); bus_strobe = 1'b0; exp_l[3] = 1'b1;
        check("R7 rmw", observed(), expected());
        access(clr_a(3), 1'b0); access(clr_a(3), 1'b0); exp_l[3] = 1'b0;
        check("R7 repeat", observed(), expected());

        // R10: address moves under held strobe, same direction
        @(negedge clk); bus_addr = AW'(BASE+1); bus_rd = 1'b0; bus_strobe = 1'b1;
        @(negedge clk); bus_addr = set_a(4);
        @(negedge clk); bus_addr = set_a(2);
        @(negedge clk); bus_strobe = 1'b0;
        check("R10 held addr", observed(), expected());

        // R8: reset in mid-state
        access(set_a(2), 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; exp_l = '0;
        check("R8 re-reset", observed(), expected());

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule